// File: doc/BRIEF.md
# Flash External Host Command Controller

This block controls an on-chip flash array while an external programmer drives the chip. Holding the device reset high and pulling the active-low host-enable pin low puts the block in host mode. From then on, the block decodes a four-bit command code formed from two 2-bit pin pairs. Reads return data at once without a clock edge. Commands that change state start when the program strobe falls. That falling edge is synchronized internally, and the block holds `busy` high for a fixed number of cycles after it.

The block has a protection gate. It accepts no strobed command until it has seen the identification read code while in host mode, and then a further delay of one millisecond has passed, counted in clock cycles. The array is split into two blocks. A block-select setting redirects only the addresses below 2000h to block 1. All higher addresses always reach block 0. A security lock refuses block erase, sector erase and byte program, and it blanks byte verify. Chip erase ignores the lock and clears it.

The behavioural array holds `2**MEM_AW` bytes per block. Each address selects its byte with its low `MEM_AW` bits, so higher addresses alias onto the same bytes. The array has no reset value, so the programmer erases it before use.

Top module: `flash_host_ctrl`

## Requirements
- R1: While `devRst` is low, or before `progEnN` has been seen low with `devRst` high, the block is not in host mode. Outside host mode, `dataOut` is 00h and `busy` is 0. Host mode lasts until `devRst` goes low.
- R2: Code 0h is the identification read; code = {`cmdHi`,`cmdLo`}. In host mode it returns BFh at address 30h, `DEV_ID` at 31h, the status byte {6'b0, sc0, lock} at 32h, and 00h at any other address. The result appears combinationally on `dataOut`.
- R3: Until the identification read code has been present at a clock edge in host mode, every strobed command is ignored. After that edge, strobed commands stay ignored for `CLK_HZ/1000` cycles.
- R4: A command started by a strobe fall that is present before edge k executes at edge k+2. For an accepted command, `busy` is then high for exactly `BUSY_CYCLES` cycles. A strobe fall that would execute while `busy` is high is ignored.
- R5: When block 1 is selected, addresses below 2000h map to block 1 and all others map to block 0. When block 0 is selected, every address maps to block 0. Code 6h selects block 0 and code 7h selects block 1.
- R6: Block 1 is selected on entry to host mode and after every chip erase.
- R7: Chip erase (code 1h) writes FFh to every byte of both blocks, even while locked. It clears the lock bit and the sc0 bit.
- R8: Block erase (code 2h) writes FFh to every byte of the selected block only. Sector erase (code 3h) writes FFh to the 128-byte sector, within the mapped block, that holds the given address. Both are refused while the lock is set. A refused command does not raise `busy`.
- R9: Byte program (code 4h) writes `dataIn` to the mapped byte. It is refused, with `busy` staying low, while the lock is set.
- R10: Byte verify (code 5h) returns the mapped byte combinationally. While the lock is set, it returns 00h.
- R11: Code 8h sets the lock bit and code 9h sets the sc0 bit. Both bits can be read back through the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| devRst | input | 1 | Device reset, high while in host mode; low resets the controller |
| progEnN | input | 1 | Active-low host mode entry |
| progStrobeN | input | 1 | Active-low program strobe; the falling edge starts a command |
| cmdHi | input | 2 | Upper pair of the command code |
| cmdLo | input | 2 | Lower pair of the command code |
| addr | input | 16 | Byte address |
| dataIn | input | 8 | Data to program |
| dataOut | output | 8 | Identification, status or verify data |
| busy | output | 1 | High while an accepted command is in progress |

## Verification
The bench first sends strobed commands before the identification read and again just after it, then sends them once the delay has run out. This separates the two arming conditions from normal acceptance. It programs bytes on both sides of the 2000h boundary under each block selection. Those reads tell the overlay apart from a plain two-block split and from aliasing within one block. Sector, block and chip erases run with data placed in neighbouring sectors and in the other block, which shows each erase's exact reach. The same commands repeated while locked show refusal both at `busy` and at the verify output.

// File: rtl/flash_host_pkg.sv
package flash_host_pkg;

  typedef enum logic [3:0] {
    CMD_READ_ID      = 4'h0,
    CMD_CHIP_ERASE   = 4'h1,
    CMD_BLOCK_ERASE  = 4'h2,
    CMD_SECTOR_ERASE = 4'h3,
    CMD_PROGRAM      = 4'h4,
    CMD_VERIFY       = 4'h5,
    CMD_SEL_BLK0     = 4'h6,
    CMD_SEL_BLK1     = 4'h7,
    CMD_SET_LOCK     = 4'h8,
    CMD_SET_SC0      = 4'h9
  } hostCmdE;

  // Strobes and levels passed from the control to the datapath
  typedef struct packed {
    logic hostOn;
    logic chipErase;
    logic blockErase;
    logic sectorErase;
    logic byteProg;
    logic blk1Sel;
    logic lockOn;
    logic sc0On;
  } dpCtrlS;

endpackage

// File: rtl/flash_host_control.sv
module flash_host_control
  import flash_host_pkg::*;
#(
  parameter int ARM_CYCLES  = 50000,
  parameter int BUSY_CYCLES = 16
) (
  input  logic       clk,
  input  logic       devRst,
  input  logic       progEnN,
  input  logic       progStrobeN,
  input  logic [3:0] cmdCode,
  output dpCtrlS     dpCtrl,
  output logic       busy,
  output logic       hostMode,
  output logic       armed
);

  localparam int ARM_W  = $clog2(ARM_CYCLES + 1);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic [1:0]        strbSync;
  logic              strbPrev;
  logic              strbFall;
  logic              idSeen;
  logic [ARM_W-1:0]  armCnt;
  logic [BUSY_W-1:0] busyCnt;
  logic              blk1Sel;
  logic              lockBit;
  logic              sc0Bit;
  logic              isStrobeCmd;
  logic              lockRefused;
  logic              accept;

  assign strbFall = strbPrev & ~strbSync[1];

  always_comb begin
    isStrobeCmd = 1'b0;
    lockRefused = 1'b0;
    case (cmdCode)
      CMD_CHIP_ERASE, CMD_SEL_BLK0, CMD_SEL_BLK1,
      CMD_SET_LOCK, CMD_SET_SC0:                  isStrobeCmd = 1'b1;
      CMD_BLOCK_ERASE, CMD_SECTOR_ERASE,
      CMD_PROGRAM: begin
        isStrobeCmd = 1'b1;
        lockRefused = lockBit;
      end
      default: isStrobeCmd = 1'b0;
    endcase
  end

  assign accept = strbFall && armed && (busyCnt == '0) && isStrobeCmd && !lockRefused;
  assign busy   = (busyCnt != '0);

  always_comb begin
    dpCtrl             = '0;
    dpCtrl.hostOn      = hostMode;
    dpCtrl.blk1Sel     = blk1Sel;
    dpCtrl.lockOn      = lockBit;
    dpCtrl.sc0On       = sc0Bit;
    dpCtrl.chipErase   = accept && (cmdCode == CMD_CHIP_ERASE);
    dpCtrl.blockErase  = accept && (cmdCode == CMD_BLOCK_ERASE);
    dpCtrl.sectorErase = accept && (cmdCode == CMD_SECTOR_ERASE);
    dpCtrl.byteProg    = accept && (cmdCode == CMD_PROGRAM);
  end

  always_ff @(posedge clk) begin
    if (!devRst) begin
      strbSync <= 2'b11;
      strbPrev <= 1'b1;
      hostMode <= 1'b0;
      idSeen   <= 1'b0;
      armed    <= 1'b0;
      armCnt   <= '0;
      busyCnt  <= '0;
      blk1Sel  <= 1'b1;
      lockBit  <= 1'b0;
      sc0Bit   <= 1'b0;
    end else begin
      strbSync <= {strbSync[0], progStrobeN};
      strbPrev <= strbSync[1];
      if (!progEnN) hostMode <= 1'b1;
      if (hostMode && cmdCode == CMD_READ_ID) idSeen <= 1'b1;
      if (idSeen && !armed) begin
        if (armCnt == ARM_W'(ARM_CYCLES - 1)) armed <= 1'b1;
        else                                  armCnt <= armCnt + 1'b1;
      end
      if (accept) begin
        busyCnt <= BUSY_W'(BUSY_CYCLES);
        case (cmdCode)
          CMD_CHIP_ERASE: begin
            lockBit <= 1'b0;
            sc0Bit  <= 1'b0;
            blk1Sel <= 1'b1;
          end
          CMD_SEL_BLK0: blk1Sel <= 1'b0;
          CMD_SEL_BLK1: blk1Sel <= 1'b1;
          CMD_SET_LOCK: lockBit <= 1'b1;
          CMD_SET_SC0:  sc0Bit  <= 1'b1;
          default: ;
        endcase
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_host_datapath.sv
module flash_host_datapath
  import flash_host_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter int         MEM_AW    = 8,
  parameter int         SECTOR_AW = 7,
  parameter logic [7:0] DEV_ID    = 8'h91
) (
  input  logic              clk,
  input  dpCtrlS            dpCtrl,
  input  logic [3:0]        cmdCode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut
);

  localparam int               DEPTH     = 2 ** MEM_AW;
  localparam int               NUM_BLK   = 2;
  localparam logic [ADDR_W-1:0] LOW_LIMIT = ADDR_W'(16'h2000);
  localparam int               SEC_W     = MEM_AW - SECTOR_AW;

  logic [7:0]        memArr [NUM_BLK][DEPTH];
  logic              tgtBlk;
  logic              selBlk;
  logic [MEM_AW-1:0] idx;
  logic [SEC_W-1:0]  secIdx;

  assign tgtBlk = dpCtrl.blk1Sel && (addr < LOW_LIMIT);
  assign selBlk = dpCtrl.blk1Sel;
  assign idx    = addr[MEM_AW-1:0];
  assign secIdx = idx[MEM_AW-1:SECTOR_AW];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BLK; b++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (dpCtrl.chipErase
            || (dpCtrl.blockErase && (b == int'(selBlk)))
            || (dpCtrl.sectorErase && (b == int'(tgtBlk))
                && ((i >> SECTOR_AW) == int'(secIdx)))) begin
          memArr[b][i] <= 8'hFF;
        end else if (dpCtrl.byteProg && (b == int'(tgtBlk)) && (i == int'(idx))) begin
          memArr[b][i] <= dataIn;
        end
      end
    end
  end

  always_comb begin
    dataOut = 8'h00;
    if (dpCtrl.hostOn) begin
      if (cmdCode == CMD_READ_ID) begin
        case (addr)
          ADDR_W'(16'h0030): dataOut = 8'hBF;
          ADDR_W'(16'h0031): dataOut = DEV_ID;
          ADDR_W'(16'h0032): dataOut = {6'b0, dpCtrl.sc0On, dpCtrl.lockOn};
          default:           dataOut = 8'h00;
        endcase
      end else if (cmdCode == CMD_VERIFY && !dpCtrl.lockOn) begin
        dataOut = memArr[tgtBlk][idx];
      end
    end
  end

endmodule

// File: rtl/flash_host_ctrl.sv
module flash_host_ctrl
  import flash_host_pkg::*;
#(
  parameter int         CLK_HZ      = 50_000_000,
  parameter int         BUSY_CYCLES = 16,
  parameter int         MEM_AW      = 8,
  parameter logic [7:0] DEV_ID      = 8'h91
) (
  input  logic        clk,
  input  logic        devRst,
  input  logic        progEnN,
  input  logic        progStrobeN,
  input  logic [1:0]  cmdHi,
  input  logic [1:0]  cmdLo,
  input  logic [15:0] addr,
  input  logic [7:0]  dataIn,
  output logic [7:0]  dataOut,
  output logic        busy
);

  localparam int ARM_CYCLES = CLK_HZ / 1000;

  dpCtrlS     dpCtrl;
  logic [3:0] cmdCode;
  logic       hostMode;
  logic       armed;

  assign cmdCode = {cmdHi, cmdLo};

  flash_host_control #(
    .ARM_CYCLES (ARM_CYCLES),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) ctrl_i (
    .clk        (clk),
    .devRst     (devRst),
    .progEnN    (progEnN),
    .progStrobeN(progStrobeN),
    .cmdCode    (cmdCode),
    .dpCtrl     (dpCtrl),
    .busy       (busy),
    .hostMode   (hostMode),
    .armed      (armed)
  );

  flash_host_datapath #(
    .ADDR_W   (16),
    .MEM_AW   (MEM_AW),
    .SECTOR_AW(7),
    .DEV_ID   (DEV_ID)
  ) dp_i (
    .clk    (clk),
    .dpCtrl (dpCtrl),
    .cmdCode(cmdCode),
    .addr   (addr),
    .dataIn (dataIn),
    .dataOut(dataOut)
  );

endmodule

// File: rtl/flash_host_ctrl_checker.sv
module flash_host_ctrl_checker (
  input logic        clk,
  input logic        devRst,
  input logic        progStrobeN,
  input logic [3:0]  cmdCode,
  input logic [15:0] addr,
  input logic [7:0]  dataOut,
  input logic        busy,
  input logic        hostMode,
  input logic        armed,
  input logic        lockOn
);

  AST_IDLE_OUTSIDE_HOST: assert property (@(posedge clk) disable iff (!devRst)
    !hostMode |-> (!busy && dataOut == 8'h00)); // R1

  AST_MFR_ID_VALUE: assert property (@(posedge clk) disable iff (!devRst)
    (hostMode && cmdCode == 4'h0 && addr == 16'h0030) |-> dataOut == 8'hBF); // R2

  AST_NO_BUSY_UNARMED: assert property (@(posedge clk) disable iff (!devRst)
    !armed |-> !busy); // R3

  AST_BUSY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!devRst)
    $rose(busy) |-> $past(progStrobeN, 3) == 1'b0); // R4

  AST_VERIFY_BLANK_LOCKED: assert property (@(posedge clk) disable iff (!devRst)
    (lockOn && cmdCode == 4'h5) |-> dataOut == 8'h00); // R10

endmodule

bind flash_host_ctrl flash_host_ctrl_checker chk_i (
  .clk        (clk),
  .devRst     (devRst),
  .progStrobeN(progStrobeN),
  .cmdCode    (cmdCode),
  .addr       (addr),
  .dataOut    (dataOut),
  .busy       (busy),
  .hostMode   (hostMode),
  .armed      (armed),
  .lockOn     (dpCtrl.lockOn)
);

// File: tb/flash_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_host_ctrl_tb_top;

  localparam int         CLK_HZ = 200_000;
  localparam int         ARM    = CLK_HZ / 1000;
  localparam int         BUSYC  = 4;
  localparam logic [7:0] DEVID  = 8'h91;

  logic        clk = 1'b0;
  logic        devRst;
  logic        progEnN;
  logic        progStrobeN;
  logic [1:0]  cmdHi;
  logic [1:0]  cmdLo;
  logic [15:0] addr;
  logic [7:0]  dataIn;
  logic [7:0]  dataOut;
  logic        busy;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  flash_host_ctrl #(
    .CLK_HZ     (CLK_HZ),
    .BUSY_CYCLES(BUSYC),
    .MEM_AW     (8),
    .DEV_ID     (DEVID)
  ) dut_i (
    .clk        (clk),
    .devRst     (devRst),
    .progEnN    (progEnN),
    .progStrobeN(progStrobeN),
    .cmdHi      (cmdHi),
    .cmdLo      (cmdLo),
    .addr       (addr),
    .dataIn     (dataIn),
    .dataOut    (dataOut),
    .busy       (busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setCmd(input logic [3:0] code);
    cmdHi = code[3:2];
    cmdLo = code[1:0];
  endtask

  // asynchronous read: drive away from the edge, sample shortly after
  task automatic readAt(input logic [3:0] code, input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    setCmd(code);
    addr = a;
    #2;
    v = dataOut;
  endtask

  task automatic expectRead(input string req, input logic [3:0] code,
                            input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] v;
    readAt(code, a, v);
    chk(req, int'(v), int'(exp));
  endtask

  // strobe a command and count the cycles busy is high afterwards
  task automatic strobe(input string req, input logic [3:0] code, input logic [15:0] a,
                        input logic [7:0] d, input bit accepted);
    int hiCnt = 0;
    @(negedge clk);
    setCmd(code);
    addr        = a;
    dataIn      = d;
    progStrobeN = 1'b0;
    for (int c = 0; c < BUSYC + 8; c++) begin
      @(negedge clk);
      if (busy) hiCnt++;
      if (c == 3) progStrobeN = 1'b1;
    end
    chk(req, hiCnt, accepted ? BUSYC : 0);
    setCmd(4'hF);
  endtask

  task automatic t_reset;
    devRst = 1'b0; progEnN = 1'b1; progStrobeN = 1'b1;
    setCmd(4'hF); addr = 16'h0; dataIn = 8'h0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 dataOut in reset", int'(dataOut), 0);
    @(negedge clk);
    devRst = 1'b1;
    expectRead("R1 id read before entry", 4'h0, 16'h0030, 8'h00);
    setCmd(4'hF);
  endtask

  task automatic t_arming;
    @(negedge clk);
    progEnN = 1'b0;
    repeat (2) @(negedge clk);
    strobe("R3 strobe before id read", 4'h1, 16'h0, 8'h0, 1'b0);
    expectRead("R2 manufacturer id", 4'h0, 16'h0030, 8'hBF);
    expectRead("R2 device id", 4'h0, 16'h0031, DEVID);
    expectRead("R2 status byte", 4'h0, 16'h0032, 8'h00);
    expectRead("R2 other address", 4'h0, 16'h0033, 8'h00);
    strobe("R3 strobe during lockout", 4'h1, 16'h0, 8'h0, 1'b0);
    repeat (ARM + 10) @(negedge clk);
  endtask

  task automatic t_chipEraseTiming;
    logic [7:0] v;
    @(negedge clk);
    setCmd(4'h1);
    progStrobeN = 1'b0;
    @(negedge clk); chk("R4 busy after edge k", int'(busy), 0);
    @(negedge clk); chk("R4 busy after edge k+1", int'(busy), 0);
    @(negedge clk); chk("R4 busy after edge k+2", int'(busy), 1);
    progStrobeN = 1'b1;
    @(negedge clk);
    setCmd(4'h4); addr = 16'h2040; dataIn = 8'h5A;
    progStrobeN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 busy last cycle", int'(busy), 1);
    @(negedge clk); chk("R4 busy ends", int'(busy), 0);
    progStrobeN = 1'b1;
    setCmd(4'hF);
    repeat (4) @(negedge clk);
    expectRead("R4 strobe during busy ignored", 4'h5, 16'h2040, 8'hFF);
    expectRead("R7 block1 erased", 4'h5, 16'h0000, 8'hFF);
    readAt(4'h5, 16'h20FF, v);
    chk("R7 block0 erased", int'(v), 8'hFF);
  endtask

  task automatic t_mapping;
    strobe("R9 program accepted", 4'h4, 16'h0005, 8'hAA, 1'b1);
    expectRead("R9 program readback", 4'h5, 16'h0005, 8'hAA);
    expectRead("R5 R6 high address to block0", 4'h5, 16'h2005, 8'hFF);
    strobe("R5 select block0", 4'h6, 16'h0, 8'h0, 1'b1);
    expectRead("R5 low address to block0", 4'h5, 16'h0005, 8'hFF);
    strobe("R9 program block0", 4'h4, 16'h3005, 8'h55, 1'b1);
    expectRead("R5 block0 alias", 4'h5, 16'h0005, 8'h55);
    strobe("R5 select block1", 4'h7, 16'h0, 8'h0, 1'b1);
    expectRead("R5 back to block1", 4'h5, 16'h0005, 8'hAA);
  endtask

  task automatic t_erases;
    strobe("R9 program sector0", 4'h4, 16'h2003, 8'h11, 1'b1);
    strobe("R9 program sector1", 4'h4, 16'h2083, 8'h22, 1'b1);
    strobe("R8 sector erase", 4'h3, 16'h2010, 8'h0, 1'b1);
    expectRead("R8 sector erased", 4'h5, 16'h2003, 8'hFF);
    expectRead("R8 neighbour sector kept", 4'h5, 16'h2083, 8'h22);
    expectRead("R8 other block kept", 4'h5, 16'h0005, 8'hAA);
    strobe("R8 block erase", 4'h2, 16'h0, 8'h0, 1'b1);
    expectRead("R8 selected block erased", 4'h5, 16'h0005, 8'hFF);
    expectRead("R8 block0 kept", 4'h5, 16'h2083, 8'h22);
  endtask

  task automatic t_lock;
    strobe("R11 set sc0", 4'h9, 16'h0, 8'h0, 1'b1);
    expectRead("R11 status sc0", 4'h0, 16'h0032, 8'h02);
    strobe("R11 set lock", 4'h8, 16'h0, 8'h0, 1'b1);
    expectRead("R11 status lock", 4'h0, 16'h0032, 8'h03);
    strobe("R9 program refused", 4'h4, 16'h2090, 8'h77, 1'b0);
    strobe("R8 sector erase refused", 4'h3, 16'h2083, 8'h0, 1'b0);
    strobe("R8 block erase refused", 4'h2, 16'h0, 8'h0, 1'b0);
    expectRead("R10 verify blanked", 4'h5, 16'h2083, 8'h00);
    strobe("R6 select block0 while locked", 4'h6, 16'h0, 8'h0, 1'b1);
    strobe("R7 chip erase while locked", 4'h1, 16'h0, 8'h0, 1'b1);
    expectRead("R7 lock and sc0 cleared", 4'h0, 16'h0032, 8'h00);
    expectRead("R7 data erased", 4'h5, 16'h2083, 8'hFF);
    strobe("R9 program after erase", 4'h4, 16'h0001, 8'h66, 1'b1);
    expectRead("R6 block1 after chip erase", 4'h5, 16'h0001, 8'h66);
    expectRead("R6 block0 untouched", 4'h5, 16'h2001, 8'hFF);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_arming();
    t_chipEraseTiming();
    t_mapping();
    t_erases();
    t_lock();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

endmodule